// File: doc/BRIEF.md
# Raster Scan-Out Address Engine

This block reads one frame of a byte-per-pixel video memory in raster order and turns it into a stream of 8-bit palette indices. Each index carries the column and row of its pixel. A start pulse launches a frame. The frame begins at a programmable base byte offset, and each line follows the previous one with no padding between them. Reads go to a synchronous memory port that returns data one cycle after the request. The output stream has a valid/ready handshake, and the engine stops requesting data whenever the consumer stalls.

When the last pixel of a frame has been handed over, a level interrupt rises. It stays high until the next write to any configuration register, which the block sees as a one-cycle pulse. Reset also clears it. If the width or the height is zero, a start pulse does nothing. The block generates no sync or porch timing and does no palette lookup.

Top module: `fb_scan_top`

## Requirements
- R1: After reset, `busy`, `irq`, `pix_valid` and `mem_rd_en` are all low. A reset applied while `irq` is high clears it.
- R2: The first read of a frame uses address `cfg_base`. Pixel (x, y) comes from address `(cfg_base + y*W + x) mod 2^ADDR_W`, so the line stride equals the width. Read data arrives one cycle after `mem_rd_en`.
- R3: Pixels come out left to right, then top to bottom. `pix_x` and `pix_y` give each pixel's position, and `pix_index` equals the memory byte at that pixel's address.
- R4: A frame that runs past the top of memory wraps to address 0 and continues from there.
- R5: A start pulse with zero width or zero height causes no read, leaves `busy` low and raises no interrupt.
- R6: A start pulse is accepted only while `busy` is low. Base, width and height are captured at the accepted pulse, so later changes to them and extra start pulses have no effect on the running frame.
- R7: `busy` rises in the cycle after an accepted start, which is also the cycle of the first read. It stays high through the handshake of the last pixel and is low in the cycle after that handshake. While `busy` is low, neither `mem_rd_en` nor `pix_valid` is asserted.
- R8: While `pix_valid` is high and `pix_ready` is low, the index and coordinates on the output hold steady. Each pixel is delivered exactly once, whatever pattern `pix_ready` follows.
- R9: `irq` goes high in the cycle after the last pixel's handshake and stays high until it is cleared.
- R10: A `cfg_wr` pulse clears `irq` in the following cycle. If `cfg_wr` falls in the same cycle as the last pixel's handshake, completion wins and `irq` is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Top-of-screen byte offset |
| cfg_width | input | DIM_W | Active pixels per line |
| cfg_height | input | DIM_W | Active lines per frame |
| cfg_wr | input | 1 | Pulse marking any configuration register write; clears the interrupt |
| sof | input | 1 | Start-of-frame request |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Consumer ready |
| pix_index | output | 8 | Palette index of the pixel |
| pix_x | output | DIM_W | Column of the pixel |
| pix_y | output | DIM_W | Row of the pixel |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Frame-complete interrupt, level |

## Verification
The interrupt has a set source (the last pixel's handshake) and a clear source (a configuration write), and both can land in the same cycle. The bench provokes this by driving `cfg_wr` in exactly the cycle where it sees the final handshake. It then checks that `irq` is high one cycle later and that a lone `cfg_wr` afterwards brings it low. The bench also sweeps a grid of small geometries with several base offsets, including some that wrap past the top of memory, under three `pix_ready` patterns. It compares every pixel with an address computed arithmetically, and it verifies that the output holds steady across each stalled cycle.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  // non-zero geometry is required before a frame may start
  function automatic logic geom_ok(input int unsigned w, input int unsigned h);
    return (w != 0) && (h != 0);
  endfunction

  // successor of a position on a ring of the given size
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned size);
    return (p + 1) % size;
  endfunction

  // column is the final one of its line
  function automatic logic line_end(input int unsigned x, input int unsigned w);
    return (x + 1) == w;
  endfunction

  // pixel is the final one of the frame
  function automatic logic frame_end(input int unsigned x, input int unsigned y,
                                     input int unsigned w, input int unsigned h);
    return line_end(x, w) && ((y + 1) == h);
  endfunction

endpackage

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
  import fbscan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic              credit_ok,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DIM_W-1:0]  tag_x,
  output logic [DIM_W-1:0]  tag_y,
  output logic              tag_last
);

  localparam int unsigned MEM_BYTES = 1 << ADDR_W;

  scan_state_e       state_q;
  logic [DIM_W-1:0]  w_q, h_q, x_q, y_q;
  logic [ADDR_W-1:0] addr_q;
  logic              issue;
  logic              at_line_end;
  logic              at_frame_end;

  assign issue        = (state_q == SCAN_RUN) && credit_ok;
  assign at_line_end  = line_end(int'(x_q), int'(w_q));
  assign at_frame_end = frame_end(int'(x_q), int'(y_q), int'(w_q), int'(h_q));

  assign rd_en    = issue;
  assign rd_addr  = addr_q;
  assign tag_x    = x_q;
  assign tag_y    = y_q;
  assign tag_last = at_frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      w_q     <= '0;
      h_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      addr_q  <= '0;
    end else if (start) begin
      state_q <= SCAN_RUN;
      w_q     <= width;
      h_q     <= height;
      x_q     <= '0;
      y_q     <= '0;
      addr_q  <= base;
    end else if (issue) begin
      addr_q <= ADDR_W'(ring_next(int'(addr_q), MEM_BYTES));
      if (at_line_end) begin
        x_q <= '0;
        y_q <= y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
      if (at_frame_end) state_q <= SCAN_IDLE;
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !at_frame_end) |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

  // R3
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCAN_RUN) |-> (x_q < w_q && y_q < h_q));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !at_frame_end && (&rd_addr)) |=> (rd_addr == '0));

endmodule

// File: rtl/fb_pix_fifo.sv
module fb_pix_fifo
  import fbscan_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         not_empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (int'(wr_ptr) == g)) slot_q[g] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ring_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ring_next(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head      = slot_q[rd_ptr];
  assign not_empty = (cnt_q != '0);
  assign count     = cnt_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (int'(cnt_q) < DEPTH));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

endmodule

// File: rtl/fb_irq_ctl.sv
module fb_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic reg_wr,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_q <= 1'b0;
    else if (frame_done) irq_q <= 1'b1;
    else if (reg_wr)     irq_q <= 1'b0;
  end

  assign irq = irq_q;

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);

  // R10
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !frame_done) |=> !irq);

endmodule

// File: rtl/fb_scan_top.sv
module fb_scan_top
  import fbscan_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DIM_W      = 11,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic              cfg_wr,
  input  logic              sof,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [7:0]        pix_index,
  output logic [DIM_W-1:0]  pix_x,
  output logic [DIM_W-1:0]  pix_y,
  output logic              busy,
  output logic              irq
);

  localparam int ENTRY_W = 8 + 2 * DIM_W + 1;
  localparam int CW      = $clog2(FIFO_DEPTH + 1);

  logic               accept;
  logic               busy_q;
  logic               credit_ok;
  logic               rd_en;
  logic [DIM_W-1:0]   tag_x, tag_y;
  logic               tag_last;
  logic               inflight_q;
  logic [DIM_W-1:0]   fx_q, fy_q;
  logic               flast_q;
  logic [ENTRY_W-1:0] push_data, head;
  logic               head_valid;
  logic [CW-1:0]      fifo_cnt;
  logic               pop;
  logic               head_last;
  logic               frame_done;

  assign accept = sof && !busy_q && geom_ok(int'(cfg_width), int'(cfg_height));
  assign pop    = head_valid && pix_ready;

  // slots held or promised must leave room for the read issued now
  assign credit_ok = (int'(fifo_cnt) + int'(inflight_q)) < (FIFO_DEPTH + int'(pop));

  fb_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) i_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .base      (cfg_base),
    .width     (cfg_width),
    .height    (cfg_height),
    .credit_ok (credit_ok),
    .rd_en     (rd_en),
    .rd_addr   (mem_addr),
    .tag_x     (tag_x),
    .tag_y     (tag_y),
    .tag_last  (tag_last)
  );

  assign mem_rd_en = rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= 1'b0;
      fx_q       <= '0;
      fy_q       <= '0;
      flast_q    <= 1'b0;
    end else begin
      inflight_q <= rd_en;
      if (rd_en) begin
        fx_q    <= tag_x;
        fy_q    <= tag_y;
        flast_q <= tag_last;
      end
    end
  end

  assign push_data = {mem_rd_data, fx_q, fy_q, flast_q};

  fb_pix_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (inflight_q),
    .push_data (push_data),
    .pop       (pop),
    .head      (head),
    .not_empty (head_valid),
    .count     (fifo_cnt)
  );

  assign pix_valid  = head_valid;
  assign pix_index  = head[ENTRY_W-1 -: 8];
  assign pix_x      = head[2*DIM_W -: DIM_W];
  assign pix_y      = head[DIM_W -: DIM_W];
  assign head_last  = head[0];
  assign frame_done = pop && head_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_q <= 1'b0;
    else if (accept)     busy_q <= 1'b1;
    else if (frame_done) busy_q <= 1'b0;
  end

  assign busy = busy_q;

  fb_irq_ctl i_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .reg_wr     (cfg_wr),
    .irq        (irq)
  );

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_index) &&
                                   $stable(pix_x) && $stable(pix_y)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !pix_valid));

  // R5
  zero_geom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !busy && (cfg_width == '0 || cfg_height == '0)) |=> !busy);

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sof));

  // R7
  first_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_rd_en);

endmodule

// File: tb/test_fb_scan_top.sv
`timescale 1ns/1ps
module test_fb_scan_top;

  localparam int AW = 8;
  localparam int DW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [DW-1:0] cfg_width = '0;
  logic [DW-1:0] cfg_height = '0;
  logic          cfg_wr = 1'b0;
  logic          sof = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rd_data = '0;
  logic          pix_valid;
  logic          pix_ready = 1'b0;
  logic [7:0]    pix_index;
  logic [DW-1:0] pix_x, pix_y;
  logic          busy, irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  fb_scan_top #(.ADDR_W(AW), .DIM_W(DW), .FIFO_DEPTH(2)) i_fb_scan_top (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_wr(cfg_wr), .sof(sof), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_index(pix_index), .pix_x(pix_x), .pix_y(pix_y),
    .busy(busy), .irq(irq)
  );

  function automatic logic [7:0] mem_byte(input int a);
    return 8'(a % 256) ^ 8'h5A;
  endfunction

  // synchronous memory model, one cycle of read latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_byte(int'(mem_addr));

  task automatic check(input string req, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int base, input int w, input int h, input int mode,
                           input bit mid_change, input bit coincide);
    int got = 0;
    int iter = 0;
    bit stall_pend = 0;
    logic [7:0] stall_val = '0;
    @(negedge clk);
    cfg_base = AW'(base); cfg_width = DW'(w); cfg_height = DW'(h); sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    check("R7 busy after start", busy === 1'b1, int'(busy), 1);
    check("R2 first address", mem_rd_en === 1'b1 && mem_addr === AW'(base),
          int'(mem_addr), base % 256);
    if (mid_change) begin
      cfg_base = AW'(base + 77); cfg_width = DW'(w + 3); cfg_height = DW'(h + 1);
      sof = 1'b1; // R6: ignored while busy
    end
    while (got < w * h && iter < 8 * w * h + 40) begin
      if (iter > 0) @(negedge clk);
      sof = 1'b0;
      iter++;
      case (mode)
        0: pix_ready = 1'b1;
        1: pix_ready = iter[0];
        default: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          pix_ready = lfsr[0] | lfsr[2];
        end
      endcase
      #1;
      if (stall_pend)
        check("R8 hold under stall", pix_valid === 1'b1 && pix_index === stall_val,
              int'(pix_index), int'(stall_val));
      stall_pend = pix_valid && !pix_ready;
      stall_val = pix_index;
      if (pix_valid && pix_ready) begin
        int ex = got % w;
        int ey = got / w;
        int ea = (base + got) % 256;
        check("R3 pixel index R2 R4 address", pix_index === mem_byte(ea),
              int'(pix_index), int'(mem_byte(ea)));
        check("R3 coordinates", pix_x === DW'(ex) && pix_y === DW'(ey),
              int'(pix_x) * 100 + int'(pix_y), ex * 100 + ey);
        got++;
        if (got == w * h && coincide) cfg_wr = 1'b1;
      end
    end
    if (got != w * h) check("R8 pixel count (watchdog)", 1'b0, got, w * h);
    @(negedge clk);
    cfg_wr = 1'b0;
    pix_ready = 1'b1;
    #1;
    check("R7 busy falls after last", busy === 1'b0, int'(busy), 0);
    check("R8 no extra pixel", pix_valid === 1'b0, int'(pix_valid), 0);
    check(coincide ? "R10 completion beats write" : "R9 irq raised", irq === 1'b1,
          int'(irq), 1);
    @(negedge clk);
    check("R9 irq held", irq === 1'b1, int'(irq), 1);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R10 irq cleared by write", irq === 1'b0, int'(irq), 0);
  endtask

  task automatic zero_geom(input int w, input int h);
    @(negedge clk);
    cfg_base = 8'h10; cfg_width = DW'(w); cfg_height = DW'(h); sof = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      sof = 1'b0;
      check("R5 zero geometry idle", !mem_rd_en && !busy && !irq,
            int'({mem_rd_en, busy, irq}), 0);
    end
  endtask

  initial begin
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", !busy && !irq && !pix_valid && !mem_rd_en,
          int'({busy, irq, pix_valid, mem_rd_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", !busy && !irq, int'({busy, irq}), 0);

    for (int w = 1; w <= 4; w++)
      for (int h = 1; h <= 3; h++)
        run_frame(w * 37 + h * 11, w, h, (w + h) % 3, 1'b0, 1'b0);

    run_frame(8'hF0, 7, 5, 2, 1'b0, 1'b0);   // R4 wrap across top
    run_frame(200, 31, 4, 1, 1'b0, 1'b0);    // R4 long wrap
    run_frame(5, 31, 1, 0, 1'b0, 1'b0);      // R2 widest line
    run_frame(60, 3, 4, 2, 1'b1, 1'b0);      // R6 mid-frame changes
    run_frame(90, 5, 2, 0, 1'b0, 1'b1);      // R10 coincident write
    run_frame(91, 2, 3, 1, 1'b0, 1'b1);      // R10 coincident under stall

    zero_geom(0, 3);
    zero_geom(4, 0);

    // R1: reset clears a pending interrupt
    @(negedge clk);
    cfg_base = 8'h00; cfg_width = 5'd2; cfg_height = 5'd1; sof = 1'b1; pix_ready = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    repeat (8) @(negedge clk);
    check("R9 irq before reset", irq === 1'b1, int'(irq), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears irq", irq === 1'b0 && busy === 1'b0, int'({irq, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule